// File: doc/BRIEF.md
# Three-wire synthesizer programming interface

This block receives programming words for a dual-channel frequency synthesizer over three slow pins: a serial data line, a serial clock and a load-enable line. All three pins are sampled in the system clock domain. Each rising edge of the serial clock pushes one data bit into a shift register. Each rising edge of load enable moves the assembled word into one of four holding registers. There is a reference-divider register and a main-divider register for each of the two channels.

Words are sent most-significant bit first, so the two control bits arrive last and sit at bit 0 and bit 1 of the word when load enable rises. Bit 0 picks the channel and bit 1 picks the register kind. The remaining fields sit at fixed positions above the control bits. A full word is 23 bits long. Bits that were shifted in earlier than the last 23 play no part. The unused top bits of each layout may hold any value.

The pins are plain asynchronous inputs and have no handshake. The holding registers drive the divider settings directly as level outputs, and each one has a flag that shows it has been written since reset.

Top module: `synth_prog_if`

## Requirements
- R1: Each rising edge of the serial clock pin shifts the sampled data pin into the word at bit 0. Earlier bits move one place up, so the last bit sent ends up at bit 0.
- R2: Each rising edge of load enable writes exactly one destination, chosen by the word. Bit 0 selects the channel (0 = first, 1 = second). Bit 1 selects the kind (0 = reference register, 1 = main register).
- R3: In a reference word, bits 3:2 give the output-select field (bit 2 is its LSB), bits 17:4 give the 14-bit reference ratio (bit 4 is its LSB), and bit 18 gives the charge-pump current select. The full range 3 to 16383 is latched exactly.
- R4: In a main word, bits 6:2 give the 5-bit swallow count (bit 2 is its LSB) and bits 19:7 give the 13-bit main counter ratio (bit 7 is its LSB).
- R5: The don't-care bits have no effect on any output. These are bits 22:19 of a reference word and bits 22:20 of a main word.
- R6: The three registers that a load does not select keep their contents. A register's valid flag goes to 1 when the register is written and stays at 1 until reset.
- R7: While rst_n is low, every field output and every valid flag is 0.
- R8: A load-enable level that stays high causes one transfer only. Bits shifted in while it is high are not transferred until the next rising edge.
- R9: If a serial clock rise and a load-enable rise are seen in the same system cycle, the transfer uses the word as it was before that bit. The bit is still shifted in.
- R10: Changes on the data pin without a serial clock rise leave the word unchanged.
- R11: If more than 23 bits are shifted before a load, only the last 23 decide the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock pin, asynchronous |
| ser_data_i | input | 1 | Serial data pin, asynchronous |
| ser_le_i | input | 1 | Load-enable pin, asynchronous |
| ref_ratio_o | output | 2x14 | Reference divide ratio per channel |
| out_sel_o | output | 2x2 | Lock-detect/output pin select per channel |
| cp_sel_o | output | 2 | Charge-pump current select per channel |
| main_ratio_o | output | 2x13 | Main counter ratio per channel |
| swallow_o | output | 2x5 | Swallow count per channel |
| ref_valid_o | output | 2 | Reference register written since reset, per channel |
| main_valid_o | output | 2 | Main register written since reset, per channel |

## Verification
Two functions can fall in the same system cycle: a shift caused by a serial clock edge and a transfer caused by a load-enable edge. To provoke this, the bench raises both pins in the same time step after a full word has been shifted in, so both edges pass the equal-depth synchronisers together. The result is judged in two steps. First, the outputs must match the word from before that bit. Second, a later load-enable pulse on its own must decode the word shifted by one place with the new bit at bit 0. That word is chosen to land in a different register.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int NCH      = 2;
  localparam int REF_W    = 14;
  localparam int MAIN_W   = 13;
  localparam int SWAL_W   = 5;
  localparam int OSEL_W   = 2;
  // control bits sit where the last two serial bits land
  localparam int SEL_POS  = 0;
  localparam int KIND_POS = 1;
  // reference layout
  localparam int OSEL_LSB = 2;
  localparam int REF_LSB  = OSEL_LSB + OSEL_W;
  localparam int CP_POS   = REF_LSB + REF_W;
  // main layout
  localparam int SWAL_LSB = 2;
  localparam int MAIN_LSB = SWAL_LSB + SWAL_W;
  localparam int MAIN_TOP = MAIN_LSB + MAIN_W - 1;
  // only bits that some layout decodes are stored
  localparam int SHREG_W  = ((CP_POS > MAIN_TOP) ? CP_POS : MAIN_TOP) + 1;

  typedef struct packed {
    logic [REF_W-1:0]  ratio;
    logic [OSEL_W-1:0] osel;
    logic              cp;
  } ref_fields_t;

  typedef struct packed {
    logic [MAIN_W-1:0] ratio;
    logic [SWAL_W-1:0] swal;
  } main_fields_t;

  function automatic ref_fields_t take_ref(input logic [SHREG_W-1:0] w);
    ref_fields_t f;
    f.ratio = w[REF_LSB +: REF_W];
    f.osel  = w[OSEL_LSB +: OSEL_W];
    f.cp    = w[CP_POS];
    return f;
  endfunction

  function automatic main_fields_t take_main(input logic [SHREG_W-1:0] w);
    main_fields_t f;
    f.ratio = w[MAIN_LSB +: MAIN_W];
    f.swal  = w[SWAL_LSB +: SWAL_W];
    return f;
  endfunction
endpackage

// File: rtl/prog_sync.sv
module prog_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/prog_rise_det.sv
module prog_rise_det #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/prog_shreg.sv
module prog_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (shift_en) q <= {q[W-2:0], bit_in};
  end
endmodule

// File: rtl/prog_latch_bank.sv
module prog_latch_bank
  import synth_prog_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          stb,
  input  logic [SHREG_W-1:0]            word,
  output logic [NCH-1:0][REF_W-1:0]     ref_ratio,
  output logic [NCH-1:0][OSEL_W-1:0]    out_sel,
  output logic [NCH-1:0]                cp_sel,
  output logic [NCH-1:0][MAIN_W-1:0]    main_ratio,
  output logic [NCH-1:0][SWAL_W-1:0]    swallow,
  output logic [NCH-1:0]                ref_valid,
  output logic [NCH-1:0]                main_valid
);
  ref_fields_t  ref_new;
  main_fields_t main_new;

  assign ref_new  = take_ref(word);
  assign main_new = take_main(word);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic         ch_hit, hit_ref, hit_main;
    ref_fields_t  ref_q;
    main_fields_t main_q;
    logic         rv_q, mv_q;

    assign ch_hit   = stb && (word[SEL_POS] == 1'(c));
    assign hit_ref  = ch_hit && !word[KIND_POS];
    assign hit_main = ch_hit &&  word[KIND_POS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ref_q <= '0;
        rv_q  <= 1'b0;
      end else if (hit_ref) begin
        ref_q <= ref_new;
        rv_q  <= 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        main_q <= '0;
        mv_q   <= 1'b0;
      end else if (hit_main) begin
        main_q <= main_new;
        mv_q   <= 1'b1;
      end
    end

    assign ref_ratio[c]  = ref_q.ratio;
    assign out_sel[c]    = ref_q.osel;
    assign cp_sel[c]     = ref_q.cp;
    assign main_ratio[c] = main_q.ratio;
    assign swallow[c]    = main_q.swal;
    assign ref_valid[c]  = rv_q;
    assign main_valid[c] = mv_q;
  end
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
  import synth_prog_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ser_clk_i,
  input  logic                          ser_data_i,
  input  logic                          ser_le_i,
  output logic [NCH-1:0][REF_W-1:0]     ref_ratio_o,
  output logic [NCH-1:0][OSEL_W-1:0]    out_sel_o,
  output logic [NCH-1:0]                cp_sel_o,
  output logic [NCH-1:0][MAIN_W-1:0]    main_ratio_o,
  output logic [NCH-1:0][SWAL_W-1:0]    swallow_o,
  output logic [NCH-1:0]                ref_valid_o,
  output logic [NCH-1:0]                main_valid_o
);
  logic [2:0]         pins_s;   // {le, sclk, data}, equal synchroniser depth
  logic [1:0]         rises;
  logic               shift_stb;
  logic               load_stb;
  logic [SHREG_W-1:0] word_q;

  prog_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({ser_le_i, ser_clk_i, ser_data_i}),
    .dout (pins_s)
  );

  prog_rise_det #(.W(2)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (pins_s[2:1]),
    .rise (rises)
  );

  assign shift_stb = rises[0];
  assign load_stb  = rises[1];

  // a coincident load reads word_q before this cycle's shift lands
  prog_shreg #(.W(SHREG_W)) u_shreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(shift_stb),
    .bit_in  (pins_s[0]),
    .q       (word_q)
  );

  prog_latch_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (load_stb),
    .word      (word_q),
    .ref_ratio (ref_ratio_o),
    .out_sel   (out_sel_o),
    .cp_sel    (cp_sel_o),
    .main_ratio(main_ratio_o),
    .swallow   (swallow_o),
    .ref_valid (ref_valid_o),
    .main_valid(main_valid_o)
  );
endmodule

// File: rtl/synth_prog_if_chk.sv
module synth_prog_if_chk
  import synth_prog_pkg::*;
(
  input logic                          clk,
  input logic                          rst_n,
  input logic                          load_stb,
  input logic [NCH-1:0][REF_W-1:0]     ref_ratio_o,
  input logic [NCH-1:0][OSEL_W-1:0]    out_sel_o,
  input logic [NCH-1:0]                cp_sel_o,
  input logic [NCH-1:0][MAIN_W-1:0]    main_ratio_o,
  input logic [NCH-1:0][SWAL_W-1:0]    swallow_o,
  input logic [NCH-1:0]                ref_valid_o,
  input logic [NCH-1:0]                main_valid_o
);
  localparam int RBITS = REF_W + OSEL_W + 1 + 1;
  localparam int MBITS = MAIN_W + SWAL_W + 1;

  logic [NCH-1:0][RBITS-1:0] ref_now, ref_prev;
  logic [NCH-1:0][MBITS-1:0] main_now, main_prev;
  logic [2*NCH-1:0]          dest_chg;

  for (genvar c = 0; c < NCH; c++) begin : g_pack
    assign ref_now[c]  = {ref_ratio_o[c], out_sel_o[c], cp_sel_o[c], ref_valid_o[c]};
    assign main_now[c] = {main_ratio_o[c], swallow_o[c], main_valid_o[c]};
    assign dest_chg[c]       = (ref_now[c]  != ref_prev[c]);
    assign dest_chg[NCH + c] = (main_now[c] != main_prev[c]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_prev  <= '0;
      main_prev <= '0;
    end else begin
      ref_prev  <= ref_now;
      main_prev <= main_now;
    end
  end

  p_one_dest_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dest_chg) <= 1);

  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_stb |=> (dest_chg == '0));

  p_valid_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ref_valid_o & $past(ref_valid_o)) == $past(ref_valid_o)) &&
             ((main_valid_o & $past(main_valid_o)) == $past(main_valid_o)));

  p_single_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> !load_stb);

  p_reset_clear_r7: assert property (@(posedge clk)
    !rst_n |-> (ref_valid_o == '0) && (main_valid_o == '0) &&
               (ref_ratio_o == '0) && (main_ratio_o == '0) &&
               (swallow_o == '0) && (out_sel_o == '0) && (cp_sel_o == '0));
endmodule

bind synth_prog_if synth_prog_if_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_stb    (load_stb),
  .ref_ratio_o (ref_ratio_o),
  .out_sel_o   (out_sel_o),
  .cp_sel_o    (cp_sel_o),
  .main_ratio_o(main_ratio_o),
  .swallow_o   (swallow_o),
  .ref_valid_o (ref_valid_o),
  .main_valid_o(main_valid_o)
);

// File: tb/test_synth_prog_if.sv
module test_synth_prog_if;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;

  logic [1:0][13:0] ref_ratio;
  logic [1:0][1:0]  out_sel;
  logic [1:0]       cp_sel;
  logic [1:0][12:0] main_ratio;
  logic [1:0][4:0]  swallow;
  logic [1:0]       ref_valid, main_valid;

  always #2 clk = ~clk;

  synth_prog_if i_synth_prog_if (
    .clk(clk), .rst_n(rst_n),
    .ser_clk_i(ser_clk), .ser_data_i(ser_data), .ser_le_i(ser_le),
    .ref_ratio_o(ref_ratio), .out_sel_o(out_sel), .cp_sel_o(cp_sel),
    .main_ratio_o(main_ratio), .swallow_o(swallow),
    .ref_valid_o(ref_valid), .main_valid_o(main_valid)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  int e_ref[2], e_osel[2], e_cp[2], e_main[2], e_swal[2], e_rv[2], e_mv[2];

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int c = 0; c < 2; c++) begin
      check_eq(req, $sformatf("ref_ratio[%0d]", c),  int'(ref_ratio[c]),  e_ref[c]);
      check_eq(req, $sformatf("out_sel[%0d]", c),    int'(out_sel[c]),    e_osel[c]);
      check_eq(req, $sformatf("cp_sel[%0d]", c),     int'(cp_sel[c]),     e_cp[c]);
      check_eq(req, $sformatf("main_ratio[%0d]", c), int'(main_ratio[c]), e_main[c]);
      check_eq(req, $sformatf("swallow[%0d]", c),    int'(swallow[c]),    e_swal[c]);
      check_eq(req, $sformatf("ref_valid[%0d]", c),  int'(ref_valid[c]),  e_rv[c]);
      check_eq(req, $sformatf("main_valid[%0d]", c), int'(main_valid[c]), e_mv[c]);
    end
  endtask

  // expected model, built from the field positions in R2..R4
  task automatic expect_word(input logic [22:0] w);
    int c;
    c = int'(w[0]);
    if (!w[1]) begin
      e_ref[c] = int'(w[17:4]); e_osel[c] = int'(w[3:2]); e_cp[c] = int'(w[18]); e_rv[c] = 1;
    end else begin
      e_main[c] = int'(w[19:7]); e_swal[c] = int'(w[6:2]); e_mv[c] = 1;
    end
  endtask

  function automatic logic [22:0] ref_word(input int ch, input int r, input int t, input int cs, input int dc);
    return {4'(dc), 1'(cs), 14'(r), 2'(t), 1'b0, 1'(ch)};
  endfunction

  function automatic logic [22:0] main_word(input int ch, input int n, input int a, input int dc);
    return {3'(dc), 13'(n), 5'(a), 1'b1, 1'(ch)};
  endfunction

  task automatic shift_bit(input logic b);
    ser_data = b; cyc(3);
    ser_clk = 1'b1; cyc(3);
    ser_clk = 1'b0; cyc(2);
  endtask

  task automatic shift_word(input logic [22:0] w);
    for (int i = 22; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic pulse_le();
    ser_le = 1'b1; cyc(4);
    ser_le = 1'b0; cyc(4);
  endtask

  task automatic send(input logic [22:0] w, input string req);
    shift_word(w);
    pulse_le();
    expect_word(w);
    check_all(req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [22:0] w1, w2, nw;
    for (int c = 0; c < 2; c++) begin
      e_ref[c] = 0; e_osel[c] = 0; e_cp[c] = 0; e_main[c] = 0; e_swal[c] = 0; e_rv[c] = 0; e_mv[c] = 0;
    end
    #1 rst_n = 1'b0;
    cyc(5);
    check_all("R7");
    rst_n = 1'b1;
    cyc(3);
    check_all("R7");

    // R3: ratio bounds, walking ones, all select combinations; R2/R6 per load
    for (int c = 0; c < 2; c++) begin
      send(ref_word(c, 3, 1, 0, 0), "R3");
      send(ref_word(c, 16383, 2, 1, 15), "R3");
      for (int b = 0; b < 14; b++) send(ref_word(c, 1 << b, b % 4, b % 2, 0), "R3");
      for (int k = 0; k < 8; k++) send(ref_word(c, 1000 + 77 * k, k % 4, k / 4, 0), "R2");
    end

    // R4: every swallow count and a walking one in the main ratio; R1 bit order
    for (int c = 0; c < 2; c++) begin
      for (int a = 0; a < 32; a++) send(main_word(c, 3 + 251 * a, a, 0), "R4");
      for (int b = 0; b < 13; b++) send(main_word(c, 1 << b, 31 - b, 0), "R1");
    end

    // R5: don't-care bits swept, fields held
    for (int c = 0; c < 2; c++) begin
      for (int d = 0; d < 16; d++) send(ref_word(c, 4660, 3, 1, d), "R5");
      for (int d = 0; d < 8; d++)  send(main_word(c, 5555, 21, d), "R5");
    end

    // R10: data wiggles without a serial clock edge
    w1 = ref_word(0, 777, 2, 0, 5);
    shift_word(w1);
    for (int i = 0; i < 6; i++) begin ser_data = ~ser_data; cyc(2); end
    pulse_le();
    expect_word(w1);
    check_all("R10");

    // R11: extra leading bits fall off the top
    for (int i = 0; i < 7; i++) shift_bit(1'(i % 3 == 0));
    send(main_word(1, 8191, 17, 7), "R11");

    // R8: held load enable gives one transfer
    w1 = ref_word(1, 9999, 1, 1, 0);
    w2 = main_word(0, 1234, 9, 0);
    shift_word(w1);
    ser_le = 1'b1; cyc(4);
    expect_word(w1);
    check_all("R8");
    shift_word(w2);
    check_all("R8");
    ser_le = 1'b0; cyc(4);
    check_all("R8");
    pulse_le();
    expect_word(w2);
    check_all("R8");

    // R9: coincident shift and load
    w1 = ref_word(1, 12345, 2, 1, 0);
    shift_word(w1);
    ser_data = 1'b1; cyc(3);
    ser_clk = 1'b1; ser_le = 1'b1; cyc(4);
    ser_clk = 1'b0; ser_le = 1'b0; cyc(4);
    expect_word(w1);
    check_all("R9");
    nw = {w1[21:0], 1'b1};
    pulse_le();
    expect_word(nw);
    check_all("R9");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule